// File: doc/BRIEF.md
# Slave-Port Arbiter with Hardware Priority Boost

This block picks which of several bus masters owns one slave port of a crossbar. Every master has a programmed priority level in two tables, a primary one and an alternate one. A select input on the slave decides which table applies. A lower level number means a higher priority.

Each master also has a hardware boost input. The slave honours a boost only when its own enable bit for that master is set. A boosted master that is requesting beats every requester that is not boosted. Among several boosted requesters, the programmed levels decide as usual. Each slave port has its own copy of this arbiter, so every slave port decides on its own.

The grant is registered. It appears one clock after the request is presented. The current owner keeps the port for as long as it both requests and holds its lock input. When nobody requests, the grant-valid flag drops and the last owner index stays on the output.

Top module: `xbar_slave_arb`

## Requirements
- R1: While reset is asserted (rst_n low), gnt is 0, gnt_vld is 0 and gnt_idx is 0.
- R2: Grant outputs are registered and appear one clock after the request. When gnt_vld is 1, gnt is one-hot with bit gnt_idx set. When gnt_vld is 0, gnt is all zero.
- R3: With no boost in effect, the requesting master with the numerically lowest level wins. Level 0 is the highest priority.
- R4: A requesting master whose boost is honoured wins over every requester without an honoured boost, whatever the programmed levels are.
- R5: When several requesters have an honoured boost, the one with the lowest programmed level among them wins.
- R6: A boost input has no effect unless the enable bit for that master (elev_en[i]) is 1.
- R7: With tbl_sel=0, levels come from prio_pri. With tbl_sel=1, they come from prio_alt. Master i's level is held in bits [3*i+2:3*i] of the table.
- R8: When competing masters have equal levels, the lower master index wins.
- R9: While the owner has gnt_vld=1 and keeps both req and hold asserted, the grant does not change. Re-arbitration takes place once the owner drops either one.
- R10: When no master requests, gnt_vld becomes 0 on the next clock and gnt_idx keeps its previous value.
- R11: A grant is only ever given to a master that was requesting in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Request per master |
| hold | input | N | Lock/burst hold per master; keeps the grant of the owner |
| elev | input | N | Hardware priority boost per master |
| elev_en | input | N | Per-master enable of the boost at this slave |
| tbl_sel | input | 1 | 0 selects the primary table, 1 the alternate table |
| prio_pri | input | N*W | Primary priority levels, W bits per master |
| prio_alt | input | N*W | Alternate priority levels, W bits per master |
| gnt | output | N | One-hot grant |
| gnt_idx | output | IW | Encoded grant index |
| gnt_vld | output | 1 | Grant valid |

## Verification
The main sweep covers every combination of request vector, boost vector and enable vector, under both table selects. This separates four cases: a plain level decision, a boost that wins, a boost that was masked off, and a tie between several boosted masters. The two tables hold different level orderings, so the winner moves with the table select. An empty request vector shows that the index is kept. Directed sequences add a table of equal levels to check the index tie-break. They also try a held owner facing a better boosted requester, followed by release through hold and through the request.

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb #(
  parameter int N = 4,
  parameter int W = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    hold,
  input  logic [N-1:0]    elev,
  input  logic [N-1:0]    elev_en,
  input  logic            tbl_sel,
  input  logic [N*W-1:0]  prio_pri,
  input  logic [N*W-1:0]  prio_alt,
  output logic [N-1:0]    gnt,
  output logic [IW-1:0]   gnt_idx,
  output logic            gnt_vld
);
  localparam int KW = 1 + W + IW;

  logic [N*W-1:0] lvl_tab;
  logic [N-1:0]   boosted;
  logic [KW-1:0]  best_key;
  logic           any_req;
  logic           keep;

  assign lvl_tab = tbl_sel ? prio_alt : prio_pri;
  assign boosted = elev & elev_en;
  assign keep    = gnt_vld && |(gnt & req & hold);

  always_comb begin
    logic [KW-1:0] k;
    best_key = '1;
    any_req  = 1'b0;
    for (int i = 0; i < N; i++) begin
      k = {~boosted[i], lvl_tab[i*W +: W], IW'(i)};
      if (req[i] && (!any_req || k < best_key)) begin
        best_key = k;
        any_req  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_idx <= '0;
      gnt_vld <= 1'b0;
    end else if (!keep) begin
      gnt_vld <= any_req;
      if (any_req) gnt_idx <= best_key[IW-1:0];
    end
  end

  assign gnt = gnt_vld ? ({{(N-1){1'b0}}, 1'b1} << gnt_idx) : '0;
endmodule

module xbar_slave_arb_chk #(
  parameter int N = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic [N-1:0]  hold,
  input logic [N-1:0]  elev,
  input logic [N-1:0]  elev_en,
  input logic [N-1:0]  gnt,
  input logic [IW-1:0] gnt_idx,
  input logic          gnt_vld
);
  // R2
  gnt_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld ? ($onehot(gnt) && gnt[gnt_idx]) : (gnt == '0));

  // R11
  gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (($past(req) & gnt) != '0));

  // R10
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req) == '0) |-> (!gnt_vld && gnt_idx == $past(gnt_idx)));

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt_vld) && (($past(gnt) & $past(req) & $past(hold)) != '0))
      |-> (gnt_vld && gnt_idx == $past(gnt_idx)));

  // R4
  boost_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(req & elev & elev_en) != '0) &&
     !($past(gnt_vld) && (($past(gnt) & $past(req) & $past(hold)) != '0)))
      |-> (($past(elev & elev_en) & gnt) != '0));
endmodule

bind xbar_slave_arb xbar_slave_arb_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .hold(hold), .elev(elev),
  .elev_en(elev_en), .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld)
);

// File: tb/sim_xbar_slave_arb.sv
module sim_xbar_slave_arb;
  localparam int N = 4, W = 3, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = 0, hold = 0, elev = 0, elev_en = 0;
  logic tbl_sel = 0;
  logic [N*W-1:0] prio_pri, prio_alt;
  logic [N-1:0] gnt;
  logic [IW-1:0] gnt_idx;
  logic gnt_vld;
  int n_chk = 0, n_fail = 0;
  int exp_idx = 0;

  always #2.5 clk = ~clk;

  xbar_slave_arb #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .hold(hold), .elev(elev),
    .elev_en(elev_en), .tbl_sel(tbl_sel), .prio_pri(prio_pri),
    .prio_alt(prio_alt), .gnt(gnt), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_of(int i, bit sel);
    return sel ? int'(prio_alt[i*W +: W]) : int'(prio_pri[i*W +: W]);
  endfunction

  function automatic int pick(logic [N-1:0] r, logic [N-1:0] e, logic [N-1:0] en, bit sel);
    int best = -1, bs = 0;
    for (int i = 0; i < N; i++) begin
      int s = ((e[i] && en[i]) ? 0 : 64) + lvl_of(i, sel) * 8 + i;
      if (r[i] && (best < 0 || s < bs)) begin best = i; bs = s; end
    end
    return best;
  endfunction

  task automatic step_check(string tag, int exp_w);
    @(posedge clk); #1;
    if (exp_w >= 0) exp_idx = exp_w;
    chk(gnt_vld == (exp_w >= 0), {tag, " vld"}, gnt_vld, exp_w >= 0);
    chk(gnt_idx == exp_idx, {tag, " idx"}, gnt_idx, exp_idx);
    chk(gnt == ((exp_w >= 0) ? (4'b1 << exp_idx) : 4'b0), "R2 onehot", gnt, (exp_w >= 0) ? (1 << exp_idx) : 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    prio_pri = {3'd0, 3'd7, 3'd2, 3'd5};
    prio_alt = {3'd4, 3'd3, 3'd6, 3'd1};
    #12;
    chk(gnt == 0 && gnt_vld == 0 && gnt_idx == 0, "R1 reset", {gnt, gnt_vld, gnt_idx}, 0);
    @(posedge clk); #1; rst_n = 1;

    for (int s = 0; s < 2; s++)
      for (int en = 0; en < 16; en++)
        for (int el = 0; el < 16; el++)
          for (int rq = 0; rq < 16; rq++) begin
            string tag;
            logic [N-1:0] bst;
            req = rq[N-1:0]; elev = el[N-1:0]; elev_en = en[N-1:0]; tbl_sel = s[0];
            bst = req & elev & elev_en;
            if (rq == 0) tag = "R10";
            else if ($countones(bst) > 1) tag = "R5";
            else if (bst != 0) tag = "R4";
            else if ((req & elev & ~elev_en) != 0) tag = "R6";
            else tag = s ? "R7" : "R3";
            step_check(tag, pick(req, elev, elev_en, tbl_sel));
          end

    // R8 equal levels
    prio_pri = {4{3'd3}}; tbl_sel = 0; elev = 0; elev_en = 0;
    req = 4'b1110; step_check("R8", 1);
    req = 4'b1001; step_check("R8", 0);
    req = 4'b0000; step_check("R10", -1);

    // R9 hold behaviour
    prio_pri = {3'd0, 3'd7, 3'd2, 3'd5};
    req = 4'b0001; hold = 4'b0001; step_check("R9 setup", 0);
    req = 4'b1111; elev = 4'b1000; elev_en = 4'b1111; step_check("R9", 0);
    step_check("R9", 0);
    hold = 4'b1000; step_check("R9 release", 3);
    req = 4'b0111; step_check("R9 req drop", 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule